// File: doc/BRIEF.md
# Push-Button Tap Position Controller

This block turns two active-low push-button inputs, one for "up" and one for "down", into a 4-bit tap code. The code selects one of sixteen taps on a resistor ladder. Both buttons are synchronized and debounced.

A press moves the tap by one step. A button that stays held repeats the step, first at a slow rate and then, after a longer hold, at a fast rate. The tap code stops at both ends and never wraps.

Pressing both buttons together cancels button commands until both are released. The one exception is the shutdown gesture: both buttons go down almost together and stay down. In shutdown the tap is forced to zero and the previous position is kept. A later debounced press of either button, or of the store-enable input, restores that position.

All timing is counted in pulses of a tick input, normally one per millisecond. A one-cycle activity pulse reports each step command to a store controller. A load port places a recalled position onto the tap at power-up.

Top module: `btn_tap_ctrl`

## Requirements
- R1: `up_n` low is a press that raises the tap by one; `dn_n` low is a press that lowers it by one. The first step comes one cycle after the press is debounced.
- R2: Inputs pass through two flip-flops before a debounce counter. A low that lasts fewer than `DB_T` counted ticks (3 in the bench) is rejected and moves nothing.
- R3: While one button stays held, the tap steps again every `SLOW_T` ticks (5 in the bench) after the first step.
- R4: Once the hold has lasted `FAST_AFTER` ticks (12 in the bench), the repeat period becomes `FAST_T` ticks (2 in the bench). Releasing the button returns the block to idle.
- R5: The tap saturates at 0 and at 15 and never wraps.
- R6: After reset the tap is mid-scale, 8 for a 4-bit tap, with `shutdown` and `activity` low.
- R7: If the second button is debounced `PAIR_T` ticks or more after the first, no further step happens until both are released. The same holds if both are debounced in the same cycle and released before shutdown.
- R8: Shutdown is entered when the second button is debounced within `PAIR_T` ticks (3 in the bench) of the first and both stay held for `SD_T` ticks (20 in the bench). The tap then reads 0, `shutdown` is 1, and the prior tap is saved. That prior tap includes the single step taken by the first press.
- R9: In shutdown, a debounced press of either button or of `store_n` restores the saved tap and clears `shutdown`, with no immediate step. A button still held then repeats after `SLOW_T` ticks.
- R10: `activity` is a one-cycle pulse for every step command, including one that is blocked at an end of the range.
- R11: `load_en` high in idle loads `load_pos` into the tap on the next clock edge. Outside shutdown, `store_n` has no effect on the tap.
- R12: Debounce, repeat and shutdown timing advance only on cycles with `tick` high. With `tick` held low, a button press moves nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timing pulse, one cycle wide per time unit |
| up_n | input | 1 | Up button, active low, asynchronous |
| dn_n | input | 1 | Down button, active low, asynchronous |
| store_n | input | 1 | Store-enable input, active low; used here only to leave shutdown |
| load_en | input | 1 | Load recalled position |
| load_pos | input | TAP_W | Recalled position |
| tap | output | TAP_W | Tap code |
| shutdown | output | 1 | Shutdown flag |
| activity | output | 1 | One-cycle pulse per step command |

## Verification
Count a press as starting at the first clock edge after the input changes, with `tick` high every cycle:
- The first step appears after edge 1 + DB_T + 2 (edge 6 in the bench): two synchronizer edges, DB_T counter edges, then the control edge.
- A held button keeps stepping only at edges up to two past its release edge, because of the two synchronizer flops.
- The repeat steps then land at edges 11, 16, 19, 21 and onward, every second edge.

The stimulus table lists hold lengths chosen against these edges. It gives the expected final tap and activity count for each hold, and each is checked ten cycles after release, once the synchronizers have emptied. The shutdown, pair-window and restore checks are likewise sampled well after the edge each is due, and always at the falling clock edge.

// File: rtl/tapc_pkg.sv
package tapc_pkg;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_HOLD,
        CS_PAIR,
        CS_LOCK,
        CS_ARM,
        CS_SHUT
    } ctl_state_e;

    typedef struct packed {
        logic st;
        logic dn;
        logic up;
    } btn_t;

    localparam int unsigned NUM_BTN = 3;

    function automatic logic [15:0] sat_step(input logic [15:0] pos,
                                             input logic        go_up,
                                             input logic [15:0] lim);
        if (go_up) return (pos == lim) ? pos : pos + 16'd1;
        else       return (pos == 16'd0) ? pos : pos - 16'd1;
    endfunction

endpackage

// File: rtl/tapc_sync.sv
module tapc_sync #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= async_i[g];
                s2 <= s1;
            end
        end
        assign sync_o[g] = s2;
    end
endmodule

// File: rtl/tapc_debounce.sv
module tapc_debounce #(
    parameter int unsigned DB_T = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic press_i,
    output logic held_o
);
    localparam int unsigned CW = $clog2(DB_T + 1);
    localparam logic [CW-1:0] CLIM = CW'(DB_T);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                       cnt <= '0;
        else if (!press_i)             cnt <= '0;
        else if (tick && cnt != CLIM)  cnt <= cnt + 1'b1;
    end

    assign held_o = press_i && (cnt == CLIM);

    AST_DEB_ON_TICK: assert property (@(posedge clk) disable iff (rst) $rose(held_o) |-> $past(tick)); // R12
endmodule

// File: rtl/tapc_ctrl.sv
module tapc_ctrl
    import tapc_pkg::*;
#(
    parameter int unsigned TAP_W      = 4,
    parameter int unsigned SLOW_T     = 250,
    parameter int unsigned FAST_AFTER = 1000,
    parameter int unsigned FAST_T     = 50,
    parameter int unsigned SD_T       = 2000,
    parameter int unsigned PAIR_T     = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  btn_t             held,
    input  logic             load_en,
    input  logic [TAP_W-1:0] load_pos,
    output logic [TAP_W-1:0] tap_o,
    output logic             shut_o,
    output logic             act_o
);
    localparam int unsigned SPAN_LIM = (FAST_AFTER > SD_T) ? FAST_AFTER : SD_T;
    localparam int unsigned SPAN_W   = $clog2(SPAN_LIM + 1);
    localparam int unsigned RC_W     = $clog2(SLOW_T + 2);
    localparam logic [TAP_W-1:0] TAP_MID = TAP_W'(1) << (TAP_W - 1);
    localparam logic [TAP_W-1:0] TAP_MAX = '1;

    ctl_state_e        state;
    logic [TAP_W-1:0]  saved;
    logic [SPAN_W-1:0] span;
    logic [RC_W-1:0]   rep;
    logic              dir_up;

    logic [TAP_W-1:0] tap_inc, tap_dec;
    logic             own, other, rep_due;
    logic [RC_W-1:0]  period;

    always_comb begin
        tap_inc = TAP_W'(sat_step(16'(tap_o), 1'b1, 16'(TAP_MAX)));
        tap_dec = TAP_W'(sat_step(16'(tap_o), 1'b0, 16'(TAP_MAX)));
        own     = dir_up ? held.up : held.dn;
        other   = dir_up ? held.dn : held.up;
        period  = (span >= SPAN_W'(FAST_AFTER)) ? RC_W'(FAST_T) : RC_W'(SLOW_T);
        rep_due = (rep + 1'b1) >= period;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= CS_IDLE;
            tap_o  <= TAP_MID;
            saved  <= TAP_MID;
            span   <= '0;
            rep    <= '0;
            dir_up <= 1'b0;
            shut_o <= 1'b0;
            act_o  <= 1'b0;
        end else begin
            act_o <= 1'b0;
            case (state)
                CS_IDLE: begin
                    if (held.up && held.dn) begin
                        state <= CS_PAIR;
                        span  <= '0;
                    end else if (held.up || held.dn) begin
                        tap_o  <= held.up ? tap_inc : tap_dec;
                        dir_up <= held.up;
                        act_o  <= 1'b1;
                        state  <= CS_HOLD;
                        span   <= '0;
                        rep    <= '0;
                    end else if (load_en) begin
                        tap_o <= load_pos;
                    end
                end
                CS_HOLD: begin
                    if (other) begin
                        if (own && span < SPAN_W'(PAIR_T)) begin
                            state <= CS_PAIR;
                            span  <= '0;
                        end else begin
                            state <= CS_LOCK;
                        end
                    end else if (!own) begin
                        state <= CS_IDLE;
                    end else if (tick) begin
                        if (span != SPAN_W'(FAST_AFTER)) span <= span + 1'b1;
                        if (rep_due) begin
                            tap_o <= dir_up ? tap_inc : tap_dec;
                            act_o <= 1'b1;
                            rep   <= '0;
                        end else begin
                            rep <= rep + 1'b1;
                        end
                    end
                end
                CS_PAIR: begin
                    if (!held.up && !held.dn) begin
                        state <= CS_IDLE;
                    end else if (!held.up || !held.dn) begin
                        state <= CS_LOCK;
                    end else if (tick) begin
                        if ((span + 1'b1) >= SPAN_W'(SD_T)) begin
                            state  <= CS_ARM;
                            saved  <= tap_o;
                            tap_o  <= '0;
                            shut_o <= 1'b1;
                        end else begin
                            span <= span + 1'b1;
                        end
                    end
                end
                CS_LOCK: begin
                    if (!held.up && !held.dn) state <= CS_IDLE;
                end
                CS_ARM: begin
                    if (!held.up && !held.dn && !held.st) state <= CS_SHUT;
                end
                CS_SHUT: begin
                    if (held.up || held.dn || held.st) begin
                        tap_o  <= saved;
                        shut_o <= 1'b0;
                        if (held.up && held.dn) begin
                            state <= CS_LOCK;
                        end else if (held.up || held.dn) begin
                            state  <= CS_HOLD;
                            dir_up <= held.up;
                            span   <= '0;
                            rep    <= '0;
                        end else begin
                            state <= CS_IDLE;
                        end
                    end
                end
                default: state <= CS_IDLE;
            endcase
        end
    end

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst) (!shut_o && !$past(shut_o) && !$past(load_en)) |-> (tap_o == $past(tap_o) || {1'b0, tap_o} == {1'b0, $past(tap_o)} + 1'b1 || {1'b0, tap_o} + 1'b1 == {1'b0, $past(tap_o)})); // R1
    AST_SHUT_ZERO: assert property (@(posedge clk) disable iff (rst) shut_o |-> tap_o == '0); // R8
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst) (state == CS_LOCK) |=> $stable(tap_o)); // R7
    AST_ACT_AWAKE: assert property (@(posedge clk) disable iff (rst) act_o |-> !shut_o && !$past(shut_o)); // R10
endmodule

// File: rtl/btn_tap_ctrl.sv
module btn_tap_ctrl
    import tapc_pkg::*;
#(
    parameter int unsigned TAP_W      = 4,
    parameter int unsigned DB_T       = 15,
    parameter int unsigned SLOW_T     = 250,
    parameter int unsigned FAST_AFTER = 1000,
    parameter int unsigned FAST_T     = 50,
    parameter int unsigned SD_T       = 2000,
    parameter int unsigned PAIR_T     = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             up_n,
    input  logic             dn_n,
    input  logic             store_n,
    input  logic             load_en,
    input  logic [TAP_W-1:0] load_pos,
    output logic [TAP_W-1:0] tap,
    output logic             shutdown,
    output logic             activity
);
    logic [NUM_BTN-1:0] raw_press, sync_press, deb;
    btn_t               held;

    assign raw_press = {~store_n, ~dn_n, ~up_n};

    tapc_sync #(.N(NUM_BTN)) u_sync (
        .clk(clk), .rst(rst), .async_i(raw_press), .sync_o(sync_press)
    );

    for (genvar g = 0; g < NUM_BTN; g++) begin : g_deb
        tapc_debounce #(.DB_T(DB_T)) u_deb (
            .clk(clk), .rst(rst), .tick(tick),
            .press_i(sync_press[g]), .held_o(deb[g])
        );
    end

    assign held = btn_t'(deb);

    tapc_ctrl #(
        .TAP_W(TAP_W), .SLOW_T(SLOW_T), .FAST_AFTER(FAST_AFTER),
        .FAST_T(FAST_T), .SD_T(SD_T), .PAIR_T(PAIR_T)
    ) u_ctrl (
        .clk(clk), .rst(rst), .tick(tick), .held(held),
        .load_en(load_en), .load_pos(load_pos),
        .tap_o(tap), .shut_o(shutdown), .act_o(activity)
    );
endmodule

// File: tb/btn_tap_ctrl_test.sv
module btn_tap_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       up_n = 1'b1, dn_n = 1'b1, store_n = 1'b1;
    logic       load_en = 1'b0;
    logic [3:0] load_pos = 4'd0;
    logic [3:0] tap;
    logic       shutdown, activity;

    int checks = 0, fails = 0, act_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    btn_tap_ctrl #(
        .TAP_W(4), .DB_T(3), .SLOW_T(5), .FAST_AFTER(12),
        .FAST_T(2), .SD_T(20), .PAIR_T(3)
    ) uut (
        .clk(clk), .rst(rst), .tick(tick), .up_n(up_n), .dn_n(dn_n),
        .store_n(store_n), .load_en(load_en), .load_pos(load_pos),
        .tap(tap), .shutdown(shutdown), .activity(activity)
    );

    always @(negedge clk) if (!rst && activity) act_cnt++;

    // {dir_up, hold cycles, expected tap, expected activity pulses}
    localparam logic [17:0] VECS [10] = '{
        {1'b1, 8'd3,  4'd8,  5'd0},
        {1'b1, 8'd4,  4'd9,  5'd1},
        {1'b1, 8'd8,  4'd10, 5'd1},
        {1'b0, 8'd9,  4'd8,  5'd2},
        {1'b1, 8'd14, 4'd11, 5'd3},
        {1'b0, 8'd17, 4'd7,  5'd4},
        {1'b1, 8'd21, 4'd13, 5'd6},
        {1'b1, 8'd30, 4'd15, 5'd10},
        {1'b0, 8'd50, 4'd0,  5'd20},
        {1'b1, 8'd10, 4'd2,  5'd2}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press_one(input bit is_up, input int hold);
        if (is_up) up_n = 1'b0; else dn_n = 1'b0;
        cyc(hold);
        up_n = 1'b1; dn_n = 1'b1;
        cyc(10);
    endtask

    task automatic press_both(input int lag, input int hold);
        up_n = 1'b0;
        cyc(lag);
        dn_n = 1'b0;
        cyc(hold);
        up_n = 1'b1; dn_n = 1'b1;
        cyc(10);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        cyc(4);
        rst = 1'b0;
        cyc(2);
        chk("R6 reset tap", tap, 8);
        chk("R6 reset shutdown", shutdown, 0);
        chk("R6 reset activity", activity, 0);

        for (int i = 0; i < 10; i++) begin
            act_cnt = 0;
            press_one(VECS[i][17], int'(VECS[i][16:9]));
            chk($sformatf("R1 R2 R3 R4 R5 vector %0d tap", i), tap, int'(VECS[i][8:5]));
            chk($sformatf("R10 vector %0d activity", i), act_cnt, int'(VECS[i][4:0]));
        end

        // R12: no tick, no movement
        tick = 1'b0; act_cnt = 0;
        press_one(1'b1, 20);
        chk("R12 tap without tick", tap, 2);
        chk("R12 activity without tick", act_cnt, 0);
        tick = 1'b1;

        // R7: simultaneous press released before shutdown
        act_cnt = 0;
        press_both(0, 10);
        chk("R7 simultaneous tap", tap, 2);
        chk("R7 simultaneous shutdown", shutdown, 0);

        // R7: second button late, then held long
        act_cnt = 0;
        press_both(8, 32);
        chk("R7 late pair tap", tap, 4);
        chk("R7 late pair activity", act_cnt, 2);
        chk("R7 late pair shutdown", shutdown, 0);

        // R8: shutdown gesture; first press stepped 4 -> 5
        up_n = 1'b0; cyc(1); dn_n = 1'b0; cyc(40);
        chk("R8 shutdown flag", shutdown, 1);
        chk("R8 shutdown tap", tap, 0);
        up_n = 1'b1; dn_n = 1'b1; cyc(10);
        chk("R8 shutdown held after release", shutdown, 1);

        // R9: leave shutdown via store input
        store_n = 1'b0; cyc(10); store_n = 1'b1; cyc(10);
        chk("R9 store exit flag", shutdown, 0);
        chk("R9 store exit tap", tap, 5);

        // R11: store input ignored outside shutdown
        store_n = 1'b0; cyc(10); store_n = 1'b1; cyc(10);
        chk("R11 store ignored", tap, 5);

        // R9: exit with short hold, no step
        press_both(0, 30);
        chk("R8 second shutdown", shutdown, 1);
        act_cnt = 0;
        press_one(1'b1, 7);
        chk("R9 button exit tap", tap, 5);
        chk("R9 button exit activity", act_cnt, 0);
        chk("R9 button exit flag", shutdown, 0);

        // R9: exit then keep holding, one repeat after SLOW_T
        press_both(0, 30);
        act_cnt = 0;
        press_one(1'b1, 12);
        chk("R9 exit then repeat tap", tap, 6);
        chk("R9 exit then repeat activity", act_cnt, 1);

        // R11 load, R5 and R10 blocked step still pulses
        load_pos = 4'd3; load_en = 1'b1; cyc(1); load_en = 1'b0; cyc(1);
        chk("R11 load 3", tap, 3);
        load_pos = 4'd15; load_en = 1'b1; cyc(1); load_en = 1'b0; cyc(1);
        act_cnt = 0;
        press_one(1'b1, 4);
        chk("R5 hold at top", tap, 15);
        chk("R10 pulse at top", act_cnt, 1);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule